// File: doc/BRIEF.md
# Sleep-Mode Interrupt Recorder and Replayer

This block sits between a set of external interrupt lines and a parent interrupt controller. Each input is brought into the clock domain through a two-flop synchronizer. It is then normalized by a per-line polarity bit, so that a logical 1 means "asserted". After that a per-line sensitivity bit classifies it as edge or level. Every qualifying event sets a per-line status latch. The latch records even while the block is disabled. Software clears latches with a write-one acknowledge.

While the block is disabled, the normalized synchronized inputs pass straight to the parent. Before sleep, software acknowledges stale latches and sets enable, usually with edge-only recording. On wake it writes the flush command. A small controller then replays every latched, unmasked line as a one-clock pulse and clears those latches. It holds the outputs quiet for one cycle afterwards.

The controller has three states. In `ST_IDLE`, outputs are passthrough or quiet. In `ST_REPLAY`, a single cycle drives the replay pulse. In `ST_SETTLE`, a single quiet cycle follows. The transitions are fixed: a flush write moves `ST_IDLE` to `ST_REPLAY`; the next clock moves `ST_REPLAY` to `ST_SETTLE`; the next clock after that moves `ST_SETTLE` to `ST_IDLE`. A flush write outside `ST_IDLE` is ignored.

Top module: `sleep_irq_recorder`

## Requirements
- R1: After reset the mask bank reads all ones for every implemented line. Sensitivity, polarity, status and control read zero. Unimplemented bits of a word read zero.
- R2: Line i is bit (i mod 32) of the word at bank base + 4*(i/32). The per-line register bases are: mask set 0x0C0, mask clear 0x100, sensitivity set 0x180, sensitivity clear 0x1C0, polarity set 0x240, polarity clear 0x280. A 1 in a set or clear write changes only that line, and a 0 leaves it unchanged. Reading either address of a bank returns the bank's current value.
- R3: The control word at 0x300 has enable in bit 0, edge-only in bit 1 and flush in bit 2. Bits 0 and 1 read back as written. Bit 2 always reads 0.
- R4: With sensitivity 0, a line latches when its synchronized input moves to the active level: rising for polarity 1, falling for polarity 0. The move to the inactive level does not latch. The latch is visible in the status word, read at the acknowledge base 0x040, in the third clock after the input changes.
- R5: With sensitivity 1, a line latches on every clock in which its synchronized, polarity-normalized input is 1. If an event and an acknowledge for the same line fall in the same cycle, the event wins.
- R6: Latching happens whether enable is 0 or 1.
- R7: When both enable and edge-only are 1, level-configured lines do not latch and edge-configured lines do. With enable 1 and edge-only 0, level lines latch again.
- R8: Writing 1s to the acknowledge words clears those latches. Bits written 0 keep their latch.
- R9: A flush write moves the controller to its replay state in the next cycle. For that one cycle the output equals status AND NOT mask, and the replayed latches clear while masked latches remain. The following cycle drives all outputs to 0.
- R10: While the controller is idle, the output equals the synchronized, polarity-normalized inputs when enable is 0, and is all 0 when enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | N_LINES | External interrupt lines, asynchronous |
| irq_out | output | N_LINES | Lines toward the parent controller |

## Verification
The hardest point to reach from the ports is the replay cycle with a mix of masked and unmasked latched lines spread across both status words. The bench builds that state in steps. With every line set to rising-edge detection, it raises and drops a chosen pattern so that only the latches remain. It then writes a separate mask pattern, issues the flush, and samples the output in exactly the cycle after the write. It repeats the flush twice: once to show that the masked latches survive, and once after unmasking to drain them. Level and edge-only cases are reached by sweeping polarity and sensitivity over disjoint line groups in both words.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int unsigned OFF_ACK      = 32'h040;
    localparam int unsigned OFF_MASK_SET = 32'h0C0;
    localparam int unsigned OFF_MASK_CLR = 32'h100;
    localparam int unsigned OFF_SENS_SET = 32'h180;
    localparam int unsigned OFF_SENS_CLR = 32'h1C0;
    localparam int unsigned OFF_POL_SET  = 32'h240;
    localparam int unsigned OFF_POL_CLR  = 32'h280;
    localparam int unsigned OFF_CTRL     = 32'h300;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REPLAY = 2'd1,
        ST_SETTLE = 2'd2
    } sirq_state_e;

    function automatic int unsigned line_word(input int unsigned base, input int unsigned line);
        return base + 4 * (line / 32);
    endfunction
endpackage

// File: rtl/sirq_detect.sv
module sirq_detect #(
    parameter int N_LINES = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] pol,
    input  logic [N_LINES-1:0] sens,
    output logic [N_LINES-1:0] norm,
    output logic [N_LINES-1:0] evt
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic meta_q, sync_q, prev_q;
        logic now_act, was_act;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= irq_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        always_comb begin
            now_act = pol[g] ? sync_q : ~sync_q;
            was_act = pol[g] ? prev_q : ~prev_q;
            norm[g] = now_act;
            evt[g]  = sens[g] ? now_act : (now_act & ~was_act);
        end
    end
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int N_LINES = 40,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [N_LINES-1:0] status,
    output logic [N_LINES-1:0] mask,
    output logic [N_LINES-1:0] sens,
    output logic [N_LINES-1:0] pol,
    output logic               en,
    output logic               edge_only,
    output logic               flush_req,
    output logic [N_LINES-1:0] ack,
    output logic [31:0]        bus_rdata
);
    function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned base,
                                input int unsigned line);
        return a == ADDR_W'(line_word(base, line));
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask      <= '1;
            sens      <= '0;
            pol       <= '0;
            en        <= 1'b0;
            edge_only <= 1'b0;
        end else if (bus_wr) begin
            for (int i = 0; i < N_LINES; i++) begin
                if (bus_wdata[i[4:0]]) begin
                    if (at(bus_addr, OFF_MASK_SET, i)) mask[i] <= 1'b1;
                    if (at(bus_addr, OFF_MASK_CLR, i)) mask[i] <= 1'b0;
                    if (at(bus_addr, OFF_SENS_SET, i)) sens[i] <= 1'b1;
                    if (at(bus_addr, OFF_SENS_CLR, i)) sens[i] <= 1'b0;
                    if (at(bus_addr, OFF_POL_SET, i))  pol[i]  <= 1'b1;
                    if (at(bus_addr, OFF_POL_CLR, i))  pol[i]  <= 1'b0;
                end
            end
            if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                en        <= bus_wdata[0];
                edge_only <= bus_wdata[1];
            end
        end
    end

    always_comb begin
        flush_req = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[2];
        for (int i = 0; i < N_LINES; i++) begin
            ack[i] = bus_wr && at(bus_addr, OFF_ACK, i) && bus_wdata[i[4:0]];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata[1:0] = {edge_only, en};
        for (int i = 0; i < N_LINES; i++) begin
            if (at(bus_addr, OFF_MASK_SET, i) || at(bus_addr, OFF_MASK_CLR, i))
                bus_rdata[i[4:0]] = mask[i];
            if (at(bus_addr, OFF_SENS_SET, i) || at(bus_addr, OFF_SENS_CLR, i))
                bus_rdata[i[4:0]] = sens[i];
            if (at(bus_addr, OFF_POL_SET, i) || at(bus_addr, OFF_POL_CLR, i))
                bus_rdata[i[4:0]] = pol[i];
            if (at(bus_addr, OFF_ACK, i))
                bus_rdata[i[4:0]] = status[i];
        end
    end
endmodule

// File: rtl/sirq_flush_fsm.sv
module sirq_flush_fsm
    import sirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    output logic replaying,
    output logic busy
);
    sirq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (flush_req) state_d = ST_REPLAY;
            ST_REPLAY: state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        replaying = (state_q == ST_REPLAY);
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/sleep_irq_recorder.sv
module sleep_irq_recorder #(
    parameter int N_LINES = 40,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic [N_LINES-1:0] irq_out
);
    logic [N_LINES-1:0] mask, sens, pol, ack, norm, evt, status, keep_off, rec;
    logic en, edge_only, flush_req, replaying, busy;

    sirq_detect #(.N_LINES(N_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol(pol), .sens(sens),
        .norm(norm), .evt(evt)
    );

    sirq_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .status(status), .mask(mask), .sens(sens),
        .pol(pol), .en(en), .edge_only(edge_only), .flush_req(flush_req),
        .ack(ack), .bus_rdata(bus_rdata)
    );

    sirq_flush_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
        .replaying(replaying), .busy(busy)
    );

    always_comb begin
        rec      = evt & ~({N_LINES{en & edge_only}} & sens);
        keep_off = ack | (replaying ? ~mask : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~keep_off) | rec;
    end

    always_comb begin
        if (replaying)          irq_out = status & ~mask;
        else if (!busy && !en)  irq_out = norm;
        else                    irq_out = '0;
    end
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker
    import sirq_pkg::*;
#(
    parameter int N_LINES = 40,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               replaying,
    input logic               busy,
    input logic               en,
    input logic [N_LINES-1:0] irq_out,
    input logic [N_LINES-1:0] status,
    input logic [N_LINES-1:0] mask,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata
);
    p_replay_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        replaying |=> !replaying);

    p_replay_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        replaying |-> (((irq_out & mask) == '0) && ((irq_out & ~status) == '0)));

    p_settle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(replaying) |-> (irq_out == '0));

    p_enabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && en) |-> (irq_out == '0));

    p_flush_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_CTRL)) |-> ((bus_rdata & 32'h4) == 32'h0));
endmodule

bind sleep_irq_recorder sirq_checker #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .replaying(replaying), .busy(busy), .en(en),
    .irq_out(irq_out), .status(status), .mask(mask), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/sleep_irq_recorder_test.sv
`timescale 1ns/1ps
module sleep_irq_recorder_test;
    localparam logic [11:0] A_ACK  = 12'h040, A_MSET = 12'h0C0, A_MCLR = 12'h100;
    localparam logic [11:0] A_SSET = 12'h180, A_SCLR = 12'h1C0;
    localparam logic [11:0] A_PSET = 12'h240, A_PCLR = 12'h280, A_CTRL = 12'h300;
    localparam logic [39:0] ALL = 40'hFF_FFFF_FFFF;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [39:0] irq_in = '0, irq_out;
    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    sleep_irq_recorder uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr_bank(input logic [11:0] a, input logic [39:0] v);
        wr(a, v[31:0]);
        wr(a + 12'd4, {24'h0, v[39:32]});
    endtask

    task automatic rd_bank(input logic [11:0] a, output logic [39:0] v);
        logic [31:0] w0, w1;
        rd(a, w0);
        rd(a + 12'd4, w1);
        v = {w1[7:0], w0};
        chk("R1 unused bits zero", {16'h0, w1[31:8]}, 40'h0);
    endtask

    task automatic settle3();
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [39:0] v, em, es, ep;
        logic [31:0] d;
        logic [39:0] pa, pb, pc, pd, pe, pm;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_bank(A_MSET, v); chk("R1 mask reset", v, ALL);
        rd_bank(A_SSET, v); chk("R1 sens reset", v, 40'h0);
        rd_bank(A_PSET, v); chk("R1 pol reset", v, 40'h0);
        rd_bank(A_ACK, v);  chk("R1 status reset", v, 40'h0);
        rd(A_CTRL, d);      chk("R1 ctrl reset", {8'h0, d}, 40'h0);
        chk("R10 passthrough active-low idle", irq_out, ALL);

        // R2 per-line sweep of every bank
        em = ALL; es = '0; ep = '0;
        for (int i = 0; i < 40; i++) begin
            logic [39:0] b;
            b = 40'h1 << i;
            wr_bank(A_MCLR, b); em &= ~b; rd_bank(A_MSET, v); chk("R2 mask clear", v, em);
            wr_bank(A_MSET, b); em |= b;  rd_bank(A_MCLR, v); chk("R2 mask set", v, em);
            wr_bank(A_SSET, b); es |= b;  rd_bank(A_SCLR, v); chk("R2 sens set", v, es);
            wr_bank(A_SCLR, b); es &= ~b; rd_bank(A_SSET, v); chk("R2 sens clear", v, es);
            wr_bank(A_PSET, b); ep |= b;  rd_bank(A_PCLR, v); chk("R2 pol set", v, ep);
            wr_bank(A_PCLR, b); ep &= ~b; rd_bank(A_PSET, v); chk("R2 pol clear", v, ep);
        end
        wr_bank(A_ACK, ALL);
        rd_bank(A_ACK, v); chk("R8 ack all", v, 40'h0);

        // R3 control
        wr(A_CTRL, 32'h2); rd(A_CTRL, d); chk("R3 ctrl edge-only", {8'h0, d}, 40'h2);
        wr(A_CTRL, 32'h0); rd(A_CTRL, d); chk("R3 ctrl cleared", {8'h0, d}, 40'h0);

        // R4 rising edges while disabled (R6), partial acknowledge (R8)
        pa = 40'hA5_0000_8421;
        wr_bank(A_PSET, ALL);
        irq_in = pa; settle3();
        rd_bank(A_ACK, v); chk("R4 R6 rising latch", v, pa);
        chk("R10 passthrough", irq_out, pa);
        irq_in = '0; settle3();
        rd_bank(A_ACK, v); chk("R4 latch held after fall", v, pa);
        wr_bank(A_ACK, 40'h00_0000_FFFF);
        rd_bank(A_ACK, v); chk("R8 partial ack", v, pa & ~40'h00_0000_FFFF);
        wr_bank(A_ACK, ALL);

        // R4 falling edge lines
        pb = 40'h0F_F000_0003;
        wr_bank(A_PCLR, pb); settle3();
        rd_bank(A_ACK, v); chk("R4 no spurious on polarity change", v, 40'h0);
        irq_in = pb; settle3();
        rd_bank(A_ACK, v); chk("R4 falling line ignores rise", v, 40'h0);
        irq_in = '0; settle3();
        rd_bank(A_ACK, v); chk("R4 falling latch", v, pb);
        wr_bank(A_ACK, ALL);
        wr_bank(A_PSET, pb);

        // R5 level lines
        pc = 40'h30_0C00_1100;
        wr_bank(A_SSET, pc);
        irq_in = pc; settle3();
        rd_bank(A_ACK, v); chk("R5 level latch", v, pc);
        wr_bank(A_ACK, ALL);
        rd_bank(A_ACK, v); chk("R5 level relatch beats ack", v, pc);
        irq_in = '0; settle3();
        wr_bank(A_ACK, ALL);
        rd_bank(A_ACK, v); chk("R8 ack after level drop", v, 40'h0);

        // R7 edge-only filtering
        pd = 40'h01_0000_0044;
        wr(A_CTRL, 32'h3);
        irq_in = pc | pd; settle3();
        rd_bank(A_ACK, v); chk("R7 edge-only drops level lines", v, pd);
        chk("R10 enabled quiet", irq_out, 40'h0);
        irq_in = '0; settle3();
        wr_bank(A_ACK, ALL);
        wr(A_CTRL, 32'h1);
        irq_in = pc; settle3();
        rd_bank(A_ACK, v); chk("R7 enabled non-edge-only records level", v, pc);
        irq_in = '0; settle3();
        wr_bank(A_ACK, ALL);
        wr_bank(A_SCLR, pc);
        rd_bank(A_ACK, v); chk("R8 clean before flush", v, 40'h0);

        // R9 flush replay
        pe = 40'h80_1234_5678;
        pm = 40'h80_0000_0070;
        irq_in = pe; settle3();
        irq_in = '0; settle3();
        rd_bank(A_ACK, v); chk("R4 flush pattern latched", v, pe);
        wr_bank(A_MCLR, ALL);
        wr_bank(A_MSET, pm);
        wr(A_CTRL, 32'h5);
        chk("R9 replay pulse", irq_out, pe & ~pm);
        @(negedge clk);
        chk("R9 settle quiet", irq_out, 40'h0);
        rd_bank(A_ACK, v); chk("R9 masked latches kept", v, pe & pm);
        rd(A_CTRL, d); chk("R3 flush reads zero", {8'h0, d}, 40'h1);
        wr(A_CTRL, 32'h5);
        chk("R9 masked not replayed", irq_out, 40'h0);
        @(negedge clk);
        wr_bank(A_MCLR, pm);
        wr(A_CTRL, 32'h5);
        chk("R9 unmasked replay", irq_out, pe & pm);
        @(negedge clk);
        chk("R9 settle quiet second", irq_out, 40'h0);
        rd_bank(A_ACK, v); chk("R9 latches drained", v, 40'h0);

        // R10 passthrough after disabling, R6 recording while disabled
        wr(A_CTRL, 32'h0);
        irq_in = 40'h55_AAAA_0001; settle3();
        chk("R10 passthrough after disable", irq_out, 40'h55_AAAA_0001);
        rd_bank(A_ACK, v); chk("R6 disabled records", v, 40'h55_AAAA_0001);

        summary();
        $finish;
    end
endmodule